// File: doc/BRIEF.md
# Two-Level Interrupt Status Reporter

This block gathers audio trap events and a few other interrupt causes into a two-tier status tree that a system-management interrupt handler walks. Each audio event input sets its own sticky bit in a second-tier register. The top-tier register has one summary bit that is set whenever any second-tier bit is set, plus one sticky bit for each generic non-audio cause. The active-low interrupt output is asserted while anything in the top tier is set.

Each tier can be read at two addresses. The observe address returns the bits and leaves them unchanged. The clearing address returns the same data and then clears what it returned. A handler reads the top tier and sees the audio summary bit. It then reads the second tier at its clearing address to learn which audio event occurred and to retire it. The audio summary bit cannot be cleared from the top tier, because it follows the second tier. Reads are a single-cycle strobe with an address. The data appears on the following cycle.

Top module: `irq_tree_top`

## Requirements
- R1: While reset is asserted, and directly after it is released, every status bit is zero, `smi_n_o` is high and `rd_data_o` is zero. Events presented during reset leave no trace.
- R2: A one-cycle pulse on `aud_evt_i[i]` sets second-tier bit i at the next clock edge. The bit stays set until a clearing read of the second tier.
- R3: A read of address 10h returns the second-tier bits in `rd_data_o[N_AUDIO-1:0]` and changes no state.
- R4: A read of address 12h returns the same data as 10h and clears the second-tier bits at that edge.
- R5: Top-tier bit 0 is set exactly while any second-tier bit is set. Reads of the top tier do not clear it.
- R6: A pulse on `gen_evt_i[j]` sets top-tier bit j+1, which is sticky. Address 00h returns the top tier without side effect. Address 02h returns the same data and clears the generic bits.
- R7: `smi_n_o` is low exactly while some top-tier bit is set. It goes high once all of those bits are cleared.
- R8: An event that arrives in the same cycle as a clearing read of its tier is set after that edge, so it is not lost.
- R9: Read data is registered and is valid the cycle after `rd_en_i`. It is zero in any cycle with no read, zero for unused bits, and zero for any address other than 00h, 02h, 10h and 12h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aud_evt_i | input | N_AUDIO | Audio event pulses, one per second-tier bit |
| gen_evt_i | input | N_GEN | Generic top-tier event pulses |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 16 | Registered read data |
| smi_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with N_AUDIO = 6 and N_GEN = 3, so that the audio sources fill only part of the second-tier word and the generic bits sit at top-tier positions 1 to 3. This width lets the bench observe how the audio summary bit and the generic bits share the top word. It also confirms that the unused upper bits read as zero. Because the tiers are narrow, the bench can reach a read of one tier's clearing address that coincides with a new event in the same tier. It can also reach the sequence in which the interrupt output stays low after a top-tier clear and rises only once the second tier has been retired.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;

  localparam int REG_W = 16;

  localparam logic [15:0] ADR_TOP_VIEW = 16'h0000;
  localparam logic [15:0] ADR_TOP_TAKE = 16'h0002;
  localparam logic [15:0] ADR_SUB_VIEW = 16'h0010;
  localparam logic [15:0] ADR_SUB_TAKE = 16'h0012;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TOP_VIEW,
    SEL_TOP_TAKE,
    SEL_SUB_VIEW,
    SEL_SUB_TAKE
  } sel_e;

  // Map a zero-extended bus address onto a register selection.
  function automatic sel_e decode_sel(input logic [15:0] a);
    case (a)
      ADR_TOP_VIEW: return SEL_TOP_VIEW;
      ADR_TOP_TAKE: return SEL_TOP_TAKE;
      ADR_SUB_VIEW: return SEL_SUB_VIEW;
      ADR_SUB_TAKE: return SEL_SUB_TAKE;
      default:      return SEL_NONE;
    endcase
  endfunction

  // Top word: bit 0 is the audio summary, generic causes sit above it.
  function automatic logic [REG_W-1:0] compose_top(input logic any_audio,
                                                   input logic [REG_W-2:0] gen_ext);
    return {gen_ext, any_audio};
  endfunction

  // Sticky update: a clear wipes the old bits, new events always land.
  function automatic logic [REG_W-1:0] sticky_next(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] evt,
                                                   input logic clr);
    return (clr ? '0 : cur) | evt;
  endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_tree_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] bits_o
);

  logic [W-1:0] bits_q;
  logic [W-1:0] bits_d;
  logic [REG_W-1:0] next_wide;

  assign next_wide = sticky_next(REG_W'(bits_q), REG_W'(evt_i), clr_i);
  assign bits_d    = next_wide[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  assign bits_o = bits_q;

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((bits_q & $past(bits_q)) == $past(bits_q)));

  // R8
  evt_kept_on_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((bits_q & $past(evt_i)) == $past(evt_i)));

  // R4
  clr_wipes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((bits_q & ~$past(evt_i)) == '0));

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_tree_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  top_word_i,
  input  logic [REG_W-1:0]  sub_word_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              clr_top_o,
  output logic              clr_sub_o
);

  sel_e             sel;
  logic [REG_W-1:0] rd_mux;
  logic [REG_W-1:0] rd_q;

  assign sel = rd_en_i ? decode_sel(16'(addr_i)) : SEL_NONE;

  always_comb begin
    case (sel)
      SEL_TOP_VIEW, SEL_TOP_TAKE: rd_mux = top_word_i;
      SEL_SUB_VIEW, SEL_SUB_TAKE: rd_mux = sub_word_i;
      default:                    rd_mux = '0;
    endcase
  end

  assign clr_top_o = (sel == SEL_TOP_TAKE);
  assign clr_sub_o = (sel == SEL_SUB_TAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_mux;
  end

  assign rd_data_o = rd_q;

  // R9
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> (rd_data_o == '0));

endmodule

// File: rtl/irq_tree_top.sv
module irq_tree_top
  import irq_tree_pkg::*;
#(
  parameter int N_AUDIO = 8,
  parameter int N_GEN   = 3,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_AUDIO-1:0] aud_evt_i,
  input  logic [N_GEN-1:0]   gen_evt_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [15:0]        rd_data_o,
  output logic               smi_n_o
);

  logic [N_AUDIO-1:0] aud_bits;
  logic [N_GEN-1:0]   gen_bits;
  logic               clr_top;
  logic               clr_sub;
  logic               any_audio;
  logic [REG_W-1:0]   top_word;
  logic [REG_W-1:0]   sub_word;

  irq_status_bank #(.W(N_AUDIO)) i_sub_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (aud_evt_i),
    .clr_i  (clr_sub),
    .bits_o (aud_bits)
  );

  irq_status_bank #(.W(N_GEN)) i_gen_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (gen_evt_i),
    .clr_i  (clr_top),
    .bits_o (gen_bits)
  );

  assign any_audio = |aud_bits;
  assign top_word  = compose_top(any_audio, (REG_W-1)'(gen_bits));
  assign sub_word  = REG_W'(aud_bits);

  irq_read_port #(.ADDR_W(ADDR_W)) i_read_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en_i    (rd_en_i),
    .addr_i     (rd_addr_i),
    .top_word_i (top_word),
    .sub_word_i (sub_word),
    .rd_data_o  (rd_data_o),
    .clr_top_o  (clr_top),
    .clr_sub_o  (clr_sub)
  );

  assign smi_n_o = ~|top_word;

  // R7
  smi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_n_o |-> (aud_bits == '0 && gen_bits == '0));

  // R5
  summary_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_top && !clr_sub && aud_bits != '0) |=> !smi_n_o);

endmodule

// File: tb/test_irq_tree_top.sv
module test_irq_tree_top;

  localparam int NA = 6;
  localparam int NG = 3;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NA-1:0] aud_evt = '0;
  logic [NG-1:0] gen_evt = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data;
  logic          smi_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  irq_tree_top #(.N_AUDIO(NA), .N_GEN(NG), .ADDR_W(AW)) i_irq_tree_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .aud_evt_i (aud_evt),
    .gen_evt_i (gen_evt),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .smi_n_o   (smi_n)
  );

  typedef struct packed {
    logic [NA-1:0] aud;
    logic [NG-1:0] gen;
    logic          rd;
    logic [AW-1:0] adr;
    logic [15:0]   exp_rd;
    logic          exp_smi_n;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{6'h05, 3'b000, 1'b0, 8'h00, 16'h0000, 1'b0}, // R2 R7: audio events, no read
    '{6'h00, 3'b000, 1'b1, 8'h00, 16'h0001, 1'b0}, // R5: summary bit visible
    '{6'h00, 3'b000, 1'b1, 8'h10, 16'h0005, 1'b0}, // R3: second-tier view
    '{6'h00, 3'b000, 1'b1, 8'h02, 16'h0001, 1'b0}, // R6: top take
    '{6'h00, 3'b000, 1'b1, 8'h00, 16'h0001, 1'b0}, // R5: summary not cleared by top
    '{6'h00, 3'b010, 1'b1, 8'h12, 16'h0005, 1'b0}, // R4 R6: sub take, generic event
    '{6'h00, 3'b000, 1'b1, 8'h00, 16'h0004, 1'b0}, // R6: generic bit at position 2
    '{6'h20, 3'b000, 1'b1, 8'h02, 16'h0004, 1'b0}, // R6: top take clears generic
    '{6'h02, 3'b000, 1'b1, 8'h12, 16'h0020, 1'b0}, // R8: event with sub take
    '{6'h00, 3'b000, 1'b1, 8'h10, 16'h0002, 1'b0}, // R8: coincident event kept
    '{6'h00, 3'b000, 1'b1, 8'h12, 16'h0002, 1'b1}, // R4 R7: last bit retired
    '{6'h00, 3'b000, 1'b1, 8'h00, 16'h0000, 1'b1}, // R7: all clear
    '{6'h00, 3'b000, 1'b1, 8'h04, 16'h0000, 1'b1}, // R9: undefined address
    '{6'h00, 3'b111, 1'b0, 8'h00, 16'h0000, 1'b0}, // R6 R9: generic, idle data
    '{6'h00, 3'b000, 1'b1, 8'h02, 16'h000E, 1'b1}, // R6 R7: top take empties tree
    '{6'h00, 3'b000, 1'b1, 8'h00, 16'h0000, 1'b1}  // R6: nothing left
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    // R1: events during reset leave no trace
    aud_evt = '1;
    gen_evt = '1;
    repeat (3) @(negedge clk);
    check("R1 smi_n in reset", 16'(smi_n), 16'h1);
    check("R1 rd_data in reset", rd_data, 16'h0);
    aud_evt = '0;
    gen_evt = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 smi_n after reset", 16'(smi_n), 16'h1);
    rd_en = 1'b1; rd_addr = 8'h00;
    @(negedge clk);
    check("R1 top view after reset", rd_data, 16'h0);
    rd_addr = 8'h10;
    @(negedge clk);
    check("R1 sub view after reset", rd_data, 16'h0);
    rd_en = 1'b0;

    for (int i = 0; i < NV; i++) begin
      aud_evt = VECS[i].aud;
      gen_evt = VECS[i].gen;
      rd_en   = VECS[i].rd;
      rd_addr = VECS[i].adr;
      @(negedge clk);
      aud_evt = '0;
      gen_evt = '0;
      rd_en   = 1'b0;
      check($sformatf("R9 table vec %0d rd_data", i), rd_data, VECS[i].exp_rd);
      check($sformatf("R7 table vec %0d smi_n", i), 16'(smi_n), 16'(VECS[i].exp_smi_n));
    end

    // R3: repeated view reads do not clear
    aud_evt = 6'h11;
    @(negedge clk);
    aud_evt = '0;
    rd_en = 1'b1; rd_addr = 8'h10;
    @(negedge clk);
    check("R3 view first", rd_data, 16'h0011);
    @(negedge clk);
    check("R3 view second", rd_data, 16'h0011);
    rd_addr = 8'h12;
    @(negedge clk);
    rd_en = 1'b0;
    check("R4 take returns", rd_data, 16'h0011);
    check("R7 smi_n released", 16'(smi_n), 16'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule